// File: doc/BRIEF.md
# PCIe Link Bring-Up Speed Sequencer

This block brings a PCIe root-port link up in two stages. A start pulse makes it cap the maximum link speed at the first generation through a read-modify-write of the speed-cap field in the link core's configuration space. Only then does it enable the link training state machine. It waits for the link to report up, raises the cap to the second generation, and sets the self-clearing directed speed-change bit. It polls that bit until the core clears it, then confirms the link is up again. If all of that succeeds, it reads the link status word to report the generation that was negotiated.

Training at the lowest speed first avoids a known failure: devices behind switches are sometimes not found when training starts at a higher rate. Every wait is bounded. A poll runs at most `POLL_MAX` times, with `GAP_CYC` idle clock cycles between attempts, so the sequence always ends in a sticky pass or fail verdict. The block reaches the core through a simple request/acknowledge register port, which carries one transaction at a time.

Top module: `link_speed_seq`

## Requirements
- R1: After a start is accepted, the first two register transactions are a read of `CAP_ADDR` and a write back to `CAP_ADDR`. The written word equals the word read, except that bits 3:0 (the speed-cap field) hold 1.
- R2: `ltssm_en_o` is low from an accepted start until the Gen1 cap write has been acknowledged. It then rises and stays high until the next accepted start.
- R3: The link-up wait samples `link_up_i` at most `POLL_MAX` times, with `GAP_CYC` cycles between samples. If it never sees the link up, `done_fail_o` rises exactly (`POLL_MAX`-1)·(`GAP_CYC`+1)+1 cycles after `ltssm_en_o` rises, and no further register access follows.
- R4: Once link-up is seen, the block reads and rewrites `CAP_ADDR` with bits 3:0 = 2, keeping the other bits. It then reads `SPD_ADDR` and writes it back with bit 17 set, keeping the other bits.
- R5: After the speed-change write, `SPD_ADDR` is read up to `POLL_MAX` times, `GAP_CYC` cycles apart. A read with bit 17 clear ends the wait. If all `POLL_MAX` reads return bit 17 set, the sequence fails.
- R6: After the speed change, `link_up_i` is sampled again under the rules of R3. Success is only possible if this second wait sees the link up.
- R7: On success, `STAT_ADDR` is read and `gen_o` takes bits 19:16 of that word. `gen_o` is 0 while `done_ok_o` is low.
- R8: `done_ok_o` and `done_fail_o` are never high together. Each one holds until the next accepted start, which clears both.
- R9: A start pulse is accepted only while `busy_o` is low. A pulse while busy leaves the transaction sequence and the verdict unchanged.
- R10: `reg_req_o` stays high, with `reg_we_o`, `reg_addr_o` and `reg_wdata_o` held steady, until `reg_ack_i`. Only one transaction is outstanding at a time.
- R11: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, taken only when idle |
| link_up_i | input | 1 | Link-up status from the link core |
| ltssm_en_o | output | 1 | Training state machine enable |
| reg_req_o | output | 1 | Register request, held until acknowledged |
| reg_we_o | output | 1 | 1 = write, 0 = read |
| reg_addr_o | output | ADDR_W | Register byte address |
| reg_wdata_o | output | DATA_W | Write data |
| reg_rdata_i | input | DATA_W | Read data, valid with acknowledge |
| reg_ack_i | input | 1 | One-cycle acknowledge |
| busy_o | output | 1 | Sequence in progress |
| done_ok_o | output | 1 | Sticky success verdict |
| done_fail_o | output | 1 | Sticky failure verdict |
| gen_o | output | GEN_W | Negotiated generation on success |

## Verification
The assertions assume the responder raises `reg_ack_i` for exactly one cycle, only while `reg_req_o` is high, and with `reg_rdata_i` valid in that same cycle. The bench's responder respects this: it acknowledges each request once, after a fixed wait of two cycles, and drops the acknowledge at the next falling edge. `link_up_i` and `start_i` may change on any cycle. The bench drives them at falling edges: it times link-up relative to the training enable, drops the link during the speed change, and pulses start in the middle of a running sequence.

// File: rtl/lss_pkg.sv
package lss_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_CAP1_RD,
      ST_CAP1_WR,
      ST_UP1_CHK,
      ST_UP1_GAP,
      ST_CAP2_RD,
      ST_CAP2_WR,
      ST_SPD_RD,
      ST_SPD_WR,
      ST_SCH_RD,
      ST_SCH_GAP,
      ST_UP2_CHK,
      ST_UP2_GAP,
      ST_STAT_RD
   } seq_state_t;

   localparam int unsigned GEN1_CODE = 1;
   localparam int unsigned GEN2_CODE = 2;

   function automatic logic is_bus_state(seq_state_t s);
      return (s == ST_CAP1_RD) || (s == ST_CAP1_WR) || (s == ST_CAP2_RD) ||
             (s == ST_CAP2_WR) || (s == ST_SPD_RD)  || (s == ST_SPD_WR)  ||
             (s == ST_SCH_RD)  || (s == ST_STAT_RD);
   endfunction

endpackage

// File: rtl/lss_bus_port.sv
module lss_bus_port #(
   parameter int unsigned ADDR_W = 12,
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go_i,
   input  logic              we_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic              done_o,
   output logic [DATA_W-1:0] rdata_o,
   output logic              busy_o,
   output logic              req_o,
   output logic              we_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic [DATA_W-1:0] wdata_o,
   input  logic              ack_i,
   input  logic [DATA_W-1:0] rdata_i
);

   logic              busy_q;
   logic              we_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic [DATA_W-1:0] rdata_q;
   logic              done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         we_q    <= 1'b0;
         addr_q  <= '0;
         wdata_q <= '0;
         rdata_q <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (!busy_q && go_i) begin
            busy_q  <= 1'b1;
            we_q    <= we_i;
            addr_q  <= addr_i;
            wdata_q <= wdata_i;
         end else if (busy_q && ack_i) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
            if (!we_q) rdata_q <= rdata_i;
         end
      end
   end

   assign busy_o  = busy_q;
   assign req_o   = busy_q;
   assign we_o    = we_q;
   assign addr_o  = addr_q;
   assign wdata_o = wdata_q;
   assign done_o  = done_q;
   assign rdata_o = rdata_q;

   AST_ONE_OP: assert property (@(posedge clk) disable iff (!rst_n)
      go_i |-> !busy_q); // R10
   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      req_o && !ack_i |=> req_o && $stable(addr_o) && $stable(we_o) && $stable(wdata_o)); // R10

endmodule

// File: rtl/lss_poll.sv
module lss_poll #(
   parameter int unsigned POLL_MAX = 200,
   parameter int unsigned GAP_CYC  = 5000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic gap_go_i,
   output logic gap_done_o,
   output logic last_o
);

   localparam int unsigned CNT_W = (POLL_MAX > 1) ? $clog2(POLL_MAX) : 1;

   logic [CNT_W-1:0] cnt_q;

   if (POLL_MAX < 1) begin : g_bad_poll
      $error("POLL_MAX must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cnt_q <= '0;
      else if (clr_i)             cnt_q <= '0;
      else if (gap_go_i && !last_o) cnt_q <= cnt_q + 1'b1;
   end

   assign last_o = (cnt_q == CNT_W'(POLL_MAX - 1));

   if (GAP_CYC <= 1) begin : g_short
      logic d_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) d_q <= 1'b0;
         else        d_q <= gap_go_i && !clr_i;
      end
      assign gap_done_o = d_q;
   end else begin : g_timer
      localparam int unsigned TW = $clog2(GAP_CYC);
      logic [TW-1:0] tmr_q;
      logic          run_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            run_q <= 1'b0;
            tmr_q <= '0;
         end else if (clr_i) begin
            run_q <= 1'b0;
            tmr_q <= '0;
         end else if (gap_go_i) begin
            run_q <= 1'b1;
            tmr_q <= TW'(GAP_CYC - 1);
         end else if (run_q) begin
            if (tmr_q == '0) run_q <= 1'b0;
            else             tmr_q <= tmr_q - 1'b1;
         end
      end
      assign gap_done_o = run_q && (tmr_q == '0);

      AST_GAP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
         run_q |-> !gap_go_i); // R3
   end

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_W'(POLL_MAX - 1)); // R5

endmodule

// File: rtl/link_speed_seq.sv
module link_speed_seq
   import lss_pkg::*;
#(
   parameter int unsigned ADDR_W   = 12,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned POLL_MAX = 200,
   parameter int unsigned GAP_CYC  = 5000,
   parameter int unsigned CAP_W    = 4,
   parameter int unsigned CAP_LSB  = 0,
   parameter int unsigned SPD_BIT  = 17,
   parameter int unsigned GEN_W    = 4,
   parameter int unsigned GEN_LSB  = 16,
   parameter logic [ADDR_W-1:0] CAP_ADDR  = 'h07C,
   parameter logic [ADDR_W-1:0] SPD_ADDR  = 'h80C,
   parameter logic [ADDR_W-1:0] STAT_ADDR = 'h080
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              link_up_i,
   output logic              ltssm_en_o,
   output logic              reg_req_o,
   output logic              reg_we_o,
   output logic [ADDR_W-1:0] reg_addr_o,
   output logic [DATA_W-1:0] reg_wdata_o,
   input  logic [DATA_W-1:0] reg_rdata_i,
   input  logic              reg_ack_i,
   output logic              busy_o,
   output logic              done_ok_o,
   output logic              done_fail_o,
   output logic [GEN_W-1:0]  gen_o
);

   localparam logic [DATA_W-1:0] FIELD_ONES = {{(DATA_W-CAP_W){1'b0}}, {CAP_W{1'b1}}};
   localparam logic [DATA_W-1:0] CAP_MASK   = FIELD_ONES << CAP_LSB;
   localparam logic [DATA_W-1:0] CAP_G1     = DATA_W'(GEN1_CODE) << CAP_LSB;
   localparam logic [DATA_W-1:0] CAP_G2     = DATA_W'(GEN2_CODE) << CAP_LSB;
   localparam logic [DATA_W-1:0] SPD_MASK   = DATA_W'(1) << SPD_BIT;

   if (CAP_LSB + CAP_W > DATA_W) begin : g_bad_cap
      $error("speed-cap field exceeds the data word");
   end
   if (SPD_BIT >= DATA_W) begin : g_bad_spd
      $error("speed-change bit exceeds the data word");
   end
   if (GEN_LSB + GEN_W > DATA_W) begin : g_bad_gen
      $error("generation field exceeds the data word");
   end
   if (CAP_W < 2) begin : g_bad_capw
      $error("speed-cap field too narrow for generation two");
   end

   seq_state_t        state_q;
   logic              sent_q;
   logic              ltssm_q;
   logic              ok_q;
   logic              fail_q;
   logic [GEN_W-1:0]  gen_q;

   logic              cmd_go;
   logic              cmd_we;
   logic [ADDR_W-1:0] cmd_addr;
   logic [DATA_W-1:0] cmd_wdata;
   logic              bus_done;
   logic [DATA_W-1:0] bus_rdata;
   logic              bus_busy;

   logic              poll_clr;
   logic              gap_go;
   logic              gap_done;
   logic              poll_last;
   logic              spd_busy;

   assign spd_busy = bus_rdata[SPD_BIT];

   lss_bus_port #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_bus (
      .clk     (clk),
      .rst_n   (rst_n),
      .go_i    (cmd_go),
      .we_i    (cmd_we),
      .addr_i  (cmd_addr),
      .wdata_i (cmd_wdata),
      .done_o  (bus_done),
      .rdata_o (bus_rdata),
      .busy_o  (bus_busy),
      .req_o   (reg_req_o),
      .we_o    (reg_we_o),
      .addr_o  (reg_addr_o),
      .wdata_o (reg_wdata_o),
      .ack_i   (reg_ack_i),
      .rdata_i (reg_rdata_i)
   );

   lss_poll #(
      .POLL_MAX (POLL_MAX),
      .GAP_CYC  (GAP_CYC)
   ) u_poll (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr_i      (poll_clr),
      .gap_go_i   (gap_go),
      .gap_done_o (gap_done),
      .last_o     (poll_last)
   );

   // Command for the register port, issued once per bus state.
   always_comb begin
      cmd_go    = 1'b0;
      cmd_we    = 1'b0;
      cmd_addr  = CAP_ADDR;
      cmd_wdata = '0;
      if (is_bus_state(state_q) && !sent_q && !bus_busy) cmd_go = 1'b1;
      case (state_q)
         ST_CAP1_WR: begin
            cmd_we    = 1'b1;
            cmd_wdata = (bus_rdata & ~CAP_MASK) | CAP_G1;
         end
         ST_CAP2_WR: begin
            cmd_we    = 1'b1;
            cmd_wdata = (bus_rdata & ~CAP_MASK) | CAP_G2;
         end
         ST_SPD_RD,
         ST_SCH_RD:  cmd_addr = SPD_ADDR;
         ST_SPD_WR: begin
            cmd_addr  = SPD_ADDR;
            cmd_we    = 1'b1;
            cmd_wdata = bus_rdata | SPD_MASK;
         end
         ST_STAT_RD: cmd_addr = STAT_ADDR;
         default: ;
      endcase
   end

   // Poll counter control.
   always_comb begin
      poll_clr = (state_q == ST_IDLE) ||
                 ((state_q == ST_CAP1_WR) && bus_done) ||
                 ((state_q == ST_SPD_WR)  && bus_done) ||
                 ((state_q == ST_SCH_RD)  && bus_done && !spd_busy);
      gap_go   = (((state_q == ST_UP1_CHK) || (state_q == ST_UP2_CHK)) &&
                  !link_up_i && !poll_last) ||
                 ((state_q == ST_SCH_RD) && bus_done && spd_busy && !poll_last);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         sent_q  <= 1'b0;
         ltssm_q <= 1'b0;
         ok_q    <= 1'b0;
         fail_q  <= 1'b0;
         gen_q   <= '0;
      end else begin
         if (cmd_go)        sent_q <= 1'b1;
         else if (bus_done) sent_q <= 1'b0;
         case (state_q)
            ST_IDLE: if (start_i) begin
               state_q <= ST_CAP1_RD;
               ok_q    <= 1'b0;
               fail_q  <= 1'b0;
               gen_q   <= '0;
               ltssm_q <= 1'b0;
            end
            ST_CAP1_RD: if (bus_done) state_q <= ST_CAP1_WR;
            ST_CAP1_WR: if (bus_done) begin
               ltssm_q <= 1'b1;
               state_q <= ST_UP1_CHK;
            end
            ST_UP1_CHK: begin
               if (link_up_i)      state_q <= ST_CAP2_RD;
               else if (poll_last) begin
                  fail_q  <= 1'b1;
                  state_q <= ST_IDLE;
               end else            state_q <= ST_UP1_GAP;
            end
            ST_UP1_GAP: if (gap_done) state_q <= ST_UP1_CHK;
            ST_CAP2_RD: if (bus_done) state_q <= ST_CAP2_WR;
            ST_CAP2_WR: if (bus_done) state_q <= ST_SPD_RD;
            ST_SPD_RD:  if (bus_done) state_q <= ST_SPD_WR;
            ST_SPD_WR:  if (bus_done) state_q <= ST_SCH_RD;
            ST_SCH_RD: if (bus_done) begin
               if (!spd_busy)      state_q <= ST_UP2_CHK;
               else if (poll_last) begin
                  fail_q  <= 1'b1;
                  state_q <= ST_IDLE;
               end else            state_q <= ST_SCH_GAP;
            end
            ST_SCH_GAP: if (gap_done) state_q <= ST_SCH_RD;
            ST_UP2_CHK: begin
               if (link_up_i)      state_q <= ST_STAT_RD;
               else if (poll_last) begin
                  fail_q  <= 1'b1;
                  state_q <= ST_IDLE;
               end else            state_q <= ST_UP2_GAP;
            end
            ST_UP2_GAP: if (gap_done) state_q <= ST_UP2_CHK;
            ST_STAT_RD: if (bus_done) begin
               gen_q   <= bus_rdata[GEN_LSB +: GEN_W];
               ok_q    <= 1'b1;
               state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign ltssm_en_o  = ltssm_q;
   assign busy_o      = (state_q != ST_IDLE);
   assign done_ok_o   = ok_q;
   assign done_fail_o = fail_q;
   assign gen_o       = gen_q;

   AST_CAP_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
      reg_req_o && reg_we_o && (reg_addr_o == CAP_ADDR) |->
      ((reg_wdata_o & CAP_MASK) == CAP_G1) || ((reg_wdata_o & CAP_MASK) == CAP_G2)); // R1
   AST_TRAIN_AFTER_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ltssm_en_o) |-> $past(reg_ack_i, 2) && $past(reg_we_o, 2) &&
      ($past(reg_addr_o, 2) == CAP_ADDR)); // R2
   AST_TRAIN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      ltssm_en_o && !(start_i && !busy_o) |=> ltssm_en_o); // R2
   AST_SPD_SET: assert property (@(posedge clk) disable iff (!rst_n)
      reg_req_o && reg_we_o && (reg_addr_o == SPD_ADDR) |-> reg_wdata_o[SPD_BIT]); // R4
   AST_GEN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !done_ok_o |-> (gen_o == '0)); // R7
   AST_VERDICT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_ok_o && done_fail_o)); // R8
   AST_OK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      done_ok_o && !start_i |=> done_ok_o); // R8
   AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      done_fail_o && !start_i |=> done_fail_o); // R8
   AST_IDLE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> !done_ok_o && !done_fail_o); // R9

endmodule

// File: tb/link_speed_seq_test.sv
module link_speed_seq_test;

   localparam int P    = 6;
   localparam int G    = 3;
   localparam int AW   = 12;
   localparam int DW   = 32;
   localparam logic [AW-1:0] A_CAP  = 12'h07C;
   localparam logic [AW-1:0] A_SPD  = 12'h80C;
   localparam logic [AW-1:0] A_STAT = 12'h080;
   localparam int FAIL_N = (P - 1) * (G + 1) + 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          link_up = 1'b0;
   logic          ltssm_en;
   logic          req, we, ack = 1'b0;
   logic [AW-1:0] addr;
   logic [DW-1:0] wdata, rdata = '0;
   logic          busy, ok, fail;
   logic [3:0]    gen;

   int checks = 0;
   int errors = 0;

   // reference model state
   int          phase = 0;
   logic [31:0] mem_cap, mem_spd, mem_stat;
   int          spd_pend = 0;
   int          spd_polls = 0;
   int          link_d = 0;
   bit          drop_mode = 0;
   bit          dropped = 0;
   bit          active = 0;
   bit          cap1_ok = 0;
   int          lt_cnt = 0;
   int          fail_n = -1;
   int          wait_n = 0;
   bit          prev_pend = 0;
   logic [AW-1:0] prev_addr;
   logic          prev_we;
   logic [DW-1:0] prev_wdata;

   always #10 clk = ~clk;

   link_speed_seq #(.POLL_MAX(P), .GAP_CYC(G)) uut (
      .clk (clk), .rst_n (rst_n), .start_i (start), .link_up_i (link_up),
      .ltssm_en_o (ltssm_en), .reg_req_o (req), .reg_we_o (we),
      .reg_addr_o (addr), .reg_wdata_o (wdata), .reg_rdata_i (rdata),
      .reg_ack_i (ack), .busy_o (busy), .done_ok_o (ok),
      .done_fail_o (fail), .gen_o (gen)
   );

   task automatic chk(input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   function automatic string tag_of(input int ph);
      if (ph <= 1) return "R1";
      if (ph <= 5) return "R4";
      if (ph == 6) return "R5";
      return "R7";
   endfunction

   task automatic serve();
      logic          exp_we;
      logic [AW-1:0] exp_a;
      logic [31:0]   exp_d;
      string         t;
      t = tag_of(phase);
      rdata = 32'hFFFF_FFFF;
      case (phase)
         0, 2: begin exp_we = 0; exp_a = A_CAP; end
         1, 3: begin exp_we = 1; exp_a = A_CAP; end
         4, 6: begin exp_we = 0; exp_a = A_SPD; end
         5:    begin exp_we = 1; exp_a = A_SPD; end
         7:    begin exp_we = 0; exp_a = A_STAT; end
         default: begin exp_we = 0; exp_a = '1; end
      endcase
      chk(t, "transaction address", 32'(addr), 32'(exp_a));
      chk(t, "transaction direction", 32'(we), 32'(exp_we));
      case (phase)
         0, 2: rdata = mem_cap;
         1: begin
            exp_d = {mem_cap[31:4], 4'h1};
            chk("R1", "gen1 cap write", wdata, exp_d);
            mem_cap = wdata; cap1_ok = 1;
         end
         3: begin
            exp_d = {mem_cap[31:4], 4'h2};
            chk("R4", "gen2 cap write", wdata, exp_d);
            chk("R4", "link up before gen2 cap", 32'(link_up), 32'd1);
            mem_cap = wdata;
         end
         4: rdata = mem_spd;
         5: begin
            exp_d = mem_spd | 32'h0002_0000;
            chk("R4", "speed change write", wdata, exp_d);
            mem_spd = wdata;
            if (drop_mode) dropped = 1;
         end
         6: begin
            spd_polls++;
            if (spd_pend > 0) spd_pend--;
            else mem_spd[17] = 1'b0;
            rdata = mem_spd;
         end
         7: rdata = mem_stat;
         default: ;
      endcase
      if (phase == 6) begin
         if (!mem_spd[17]) phase = 7;
      end else if (phase < 8) phase++;
   endtask

   // per-clock model: responder, link driver and protocol comparison
   initial begin
      forever begin
         @(negedge clk);
         #1;
         if (rst_n) begin
            if (prev_pend)
               chk("R10", "request held until ack",
                   32'(req && addr == prev_addr && we == prev_we && wdata == prev_wdata), 32'd1);
            if (active) chk("R2", "training gated by gen1 cap",
                            32'(ltssm_en && !cap1_ok), 32'd0);
            chk("R8", "verdicts exclusive", 32'(ok && fail), 32'd0);
            if (ack) begin
               ack = 1'b0;
               wait_n = 0;
            end else if (req) begin
               if (wait_n < 2) wait_n++;
               else begin
                  serve();
                  ack = 1'b1;
               end
            end
            prev_pend  = req && !ack;
            prev_addr  = addr;
            prev_we    = we;
            prev_wdata = wdata;
            if (ltssm_en) begin
               if (fail && fail_n < 0) fail_n = lt_cnt;
               link_up = (lt_cnt >= link_d) && !dropped;
               lt_cnt++;
            end else begin
               lt_cnt  = 0;
               link_up = 1'b0;
            end
         end
      end
   end

   task automatic run_case(input string name, input int d, input int k,
                           input bit drop, input logic [31:0] stat,
                           input bit mid, input bit exp_ok,
                           input int exp_phase, input int exp_polls,
                           input int exp_fn);
      bit mid_done = 0;
      bit done = 0;
      @(negedge clk);
      phase = 0; mem_cap = 32'hC3A5_96F7; mem_spd = 32'h0000_0A41;
      mem_stat = stat; spd_pend = k; link_d = d; drop_mode = drop;
      dropped = 0; spd_polls = 0; fail_n = -1;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0; cap1_ok = 0; active = 1;
      chk("R8", {name, " verdicts cleared by start"}, {30'd0, ok, fail}, 32'd0);
      chk("R9", {name, " busy after start"}, 32'(busy), 32'd1);
      chk("R2", {name, " training off after start"}, 32'(ltssm_en), 32'd0);
      for (int n = 0; n < 3000 && !done; n++) begin
         @(negedge clk);
         if (mid && !mid_done && phase == 4) begin
            chk("R9", {name, " busy when second start arrives"}, 32'(busy), 32'd1);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            mid_done = 1;
         end
         if (ok || fail) done = 1;
      end
      #2;
      if (!done) chk("R3", {name, " watchdog: sequence ended"}, 32'd0, 32'd1);
      chk(exp_ok ? "R6" : "R3", {name, " success verdict"}, 32'(ok), 32'(exp_ok));
      chk(exp_ok ? "R6" : "R3", {name, " failure verdict"}, 32'(fail), 32'(!exp_ok));
      chk("R7", {name, " generation"}, 32'(gen), exp_ok ? 32'(stat[19:16]) : 32'd0);
      chk("R9", {name, " model phase"}, 32'(phase), 32'(exp_phase));
      if (exp_polls >= 0) chk("R5", {name, " speed polls"}, 32'(spd_polls), 32'(exp_polls));
      if (exp_fn >= 0) chk("R3", {name, " fail timing"}, 32'(fail_n), 32'(exp_fn));
      repeat (12) @(negedge clk);
      #2;
      chk("R8", {name, " verdict sticky"}, {30'd0, ok, fail}, {30'd0, exp_ok, !exp_ok});
      chk("R2", {name, " training held"}, 32'(ltssm_en), 32'd1);
   endtask

   initial begin
      #(200000 * 20);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      #2;
      chk("R11", "reset outputs",
          {22'd0, ltssm_en, req, busy, ok, fail, gen, we}, 32'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      #2;
      chk("R11", "idle after reset", {29'd0, busy, ok, fail}, 32'd0);
      // normal bring-up, gen 2
      run_case("normal", 4, 2, 0, 32'h0012_0003, 0, 1, 8, 3, -1);
      // second start in mid-sequence is ignored
      run_case("midstart", 0, 0, 0, 32'h0001_0000, 1, 1, 8, 1, -1);
      // link never trains
      run_case("nolink", 1000, 0, 0, 32'h0002_0000, 0, 0, 2, -1, FAIL_N);
      // link arrives exactly at the last sample
      run_case("lastsample", FAIL_N - 1, 0, 0, 32'h0003_0000, 0, 1, 8, 1, -1);
      // link one cycle too late
      run_case("toolate", FAIL_N, 0, 0, 32'h0003_0000, 0, 0, 2, -1, FAIL_N);
      // speed change clears on the final allowed poll
      run_case("spdlast", 2, P - 1, 0, 32'h0002_0000, 0, 1, 8, P, -1);
      // speed change never clears
      run_case("spdstuck", 2, P, 0, 32'h0002_0000, 0, 0, 6, P, -1);
      // link lost during the speed change
      run_case("linkdrop", 2, 1, 1, 32'h0002_0000, 0, 0, 7, 2, -1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule